// File: doc/BRIEF.md
# I2C bus recovery sequencer

This block sits beside an I2C controller and frees a bus left hung by a target that has lost track of where it is in a transfer. When it receives a start request, it takes over the clock and data lines through open-drain pull-low enables. It watches both lines through a synchroniser and runs one of two recovery procedures. It reports the outcome as a two-bit code with a one-cycle completion strobe.

The interleaved mode issues nine clock pulses. Before each pulse it places a START condition on the bus, but only if the data line reads high at that moment. If the data line is held low, that pulse goes out without a START. This mode always closes with a STOP.

The conditional mode first checks the data line. If the data line is high, the block only issues a STOP. If it is low, the block toggles the clock up to nine times and stops toggling as soon as the data line is released. A target that never releases the data line gives a "needs hardware reset" code. A clock line that never rises gives a "clock stuck" code.

All timing intervals are parameters counted in system clock cycles:
- the START settle time,
- the inter-pulse gap,
- the SCL low and high half-periods,
- the STOP propagation time,
- the clock-stretch timeout.

The SCL high half-period and the propagation time must each be at least 3 cycles so that the synchronised line levels are current when the block decides on them.

Top module: `i2c_bus_recover`

## Requirements
- R1: With `mode_i`=0 on a free bus, the SCL line shows exactly nine pulses, each preceded by a START (SDA falls while SCL is high), plus one further SCL rise inside the closing STOP.
- R2: A sequence that recovers the bus ends with a STOP (SDA rises while SCL is high). When `done_o` is high, both `scl_low_o` and `sda_low_o` are 0.
- R3: Each START is held for SETTLE_CYC cycles before SCL is pulled low. A gap of GAP_CYC cycles with SCL high follows every pulse except the ninth. With the bench's parameters, one interleaved run on a free bus keeps `busy_o` high for exactly 234 cycles.
- R4: After the closing STOP, the block waits PROP_CYC cycles before raising `done_o`.
- R5: With `mode_i`=1 and SDA high at the start, the block issues only a STOP (one SCL pulse) and returns result 2'b00.
- R6: With `mode_i`=1 and SDA low, the block pulses SCL and checks SDA at the end of each high phase. At the first high reading it issues a STOP and returns 2'b00, including when the release comes in the ninth pulse.
- R7: With `mode_i`=1 and SDA still low after nine pulses, the block returns 2'b01 and issues no STOP.
- R8: If SCL does not read high within STRETCH_CYC cycles of being released, at the start or during any pulse, the block returns 2'b10 and releases both lines.
- R9: A START is issued only when SDA reads high. With `mode_i`=0, a pulse due while SDA is held low goes out without a START. An interleaved run whose SDA stays low to the end returns 2'b01.
- R10: After releasing SCL, the block waits for SCL to read high before timing the high phase, so a target holding SCL low for less than STRETCH_CYC cycles does not change the outcome.
- R11: A start request is accepted only while `busy_o` is 0. A request during a run changes neither the mode nor the sequence, and it produces no second `done_o`.
- R12: `done_o` is high for one cycle, in the cycle `busy_o` falls. `result_o` keeps its value from that cycle until a later run completes.
- R13: After reset, `scl_low_o`, `sda_low_o`, `busy_o` and `done_o` are 0, and `result_o` is 2'b00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request a recovery run (taken when idle) |
| mode_i | input | 1 | 0 = START before every pulse, 1 = SDA-conditional |
| scl_i | input | 1 | Sensed SCL level (asynchronous) |
| sda_i | input | 1 | Sensed SDA level (asynchronous) |
| scl_low_o | output | 1 | Pull SCL low when 1, release when 0 |
| sda_low_o | output | 1 | Pull SDA low when 1, release when 0 |
| busy_o | output | 1 | A recovery run is in progress |
| done_o | output | 1 | One-cycle strobe at the end of a run |
| result_o | output | 2 | 00 recovered, 01 SDA stuck (hardware reset needed), 10 SCL stuck |

## Verification
The bench models a target on the open-drain lines. Depending on the case, the target is absent, holds SDA until the first SCL fall after a chosen pulse, holds SDA for ever, stretches SCL briefly, or grabs SCL permanently. Each case is run in both modes where the mode matters. Counting START, STOP and SCL rise events on the wires separates the two modes. The count of STARTs shows whether a START is withheld while SDA is low. Releasing SDA during pulse four and again during pulse nine checks that the block stops toggling at the right pulse. A short clock stretch and a permanent clock stretch must give different results, which shows the stretch wait is separate from the stuck-clock timeout. The busy cycle count and the STOP-to-done distance pin down the settle, gap-skip and propagation timing.

// File: rtl/i2crec_pkg.sv
package i2crec_pkg;

  typedef enum logic [1:0] {
    RES_OK        = 2'b00,
    RES_SDA_STUCK = 2'b01,
    RES_SCL_STUCK = 2'b10
  } rec_result_e;

  typedef enum logic [3:0] {
    S_IDLE,
    S_INIT,   // release both, wait for SCL high
    S_START,  // SDA low with SCL high (START held)
    S_SHOLD,  // SCL pulled low while SDA still low
    S_CLO,    // SCL low, SDA released
    S_CREL,   // SCL released, waiting for it to read high
    S_CHI,    // SCL high phase
    S_GAP,    // inter-pulse gap, SCL high
    S_PPREP,  // STOP: SCL low, SDA released
    S_PLO,    // STOP: SCL low, SDA low
    S_PREL,   // STOP: SCL released, waiting for high
    S_PHI,    // STOP: SCL high, SDA low
    S_PROP    // STOP done: both released, propagation wait
  } rec_state_e;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/rec_sync.sv
module rec_sync #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  // Bus lines idle high, so both stages reset to 1.
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic meta_q, sync_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b1;
        sync_q <= 1'b1;
      end else begin
        meta_q <= d[i];
        sync_q <= meta_q;
      end
    end
    assign q[i] = sync_q;
  end
endmodule

// File: rtl/rec_timer.sv
module rec_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          expired
);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (load)           cnt <= load_val;
    else if (cnt != '0)      cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

  // R3: once loaded, the countdown reaches zero and stays there until reloaded
  hold_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt == '0) |=> (cnt == '0));
endmodule

// File: rtl/i2c_bus_recover.sv
module i2c_bus_recover
  import i2crec_pkg::*;
#(
  parameter int NUM_PULSES  = 9,
  parameter int SETTLE_CYC  = 750,
  parameter int GAP_CYC     = 250,
  parameter int LO_CYC      = 250,
  parameter int HI_CYC      = 250,
  parameter int PROP_CYC    = 750,
  parameter int STRETCH_CYC = 5000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       mode_i,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       scl_low_o,
  output logic       sda_low_o,
  output logic       busy_o,
  output logic       done_o,
  output logic [1:0] result_o
);
  localparam int MAXC = max2(max2(max2(SETTLE_CYC, GAP_CYC), max2(LO_CYC, HI_CYC)),
                             max2(PROP_CYC, STRETCH_CYC));
  localparam int TW = $clog2(MAXC + 1);
  localparam int PW = $clog2(NUM_PULSES + 1);

  rec_state_e  st, nxt;
  logic        mode_q;
  logic [PW-1:0] pcnt;
  logic        pinc, fin;
  rec_result_e fin_code, res_q;
  logic        scl_low_q, sda_low_q, done_q;
  logic [1:0]  line_s;
  logic        scl_s, sda_s;
  logic        tmr_load, tmr_exp;
  logic [TW-1:0] tmr_val;
  logic        last_pulse;

  // Line sampling
  rec_sync #(.W(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({scl_i, sda_i}),
    .q     (line_s)
  );
  assign scl_s = line_s[1];
  assign sda_s = line_s[0];

  // Interval timing
  function automatic logic [TW-1:0] dur_of(input rec_state_e s);
    case (s)
      S_INIT, S_CREL, S_PREL:         dur_of = TW'(STRETCH_CYC - 1);
      S_START:                        dur_of = TW'(SETTLE_CYC - 1);
      S_SHOLD, S_CLO, S_PPREP, S_PLO: dur_of = TW'(LO_CYC - 1);
      S_CHI, S_PHI:                   dur_of = TW'(HI_CYC - 1);
      S_GAP:                          dur_of = TW'(GAP_CYC - 1);
      S_PROP:                         dur_of = TW'(PROP_CYC - 1);
      default:                        dur_of = '0;
    endcase
  endfunction

  assign tmr_load = (nxt != st);
  assign tmr_val  = dur_of(nxt);

  rec_timer #(.TW(TW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_exp)
  );

  // Sequencing
  assign last_pulse = (pcnt == PW'(NUM_PULSES - 1));

  always_comb begin
    nxt      = st;
    fin      = 1'b0;
    fin_code = RES_OK;
    pinc     = 1'b0;
    case (st)
      S_IDLE:  if (start_i) nxt = S_INIT;
      S_INIT: begin
        if (scl_s) begin
          if (mode_q) nxt = sda_s ? S_PPREP : S_CLO;
          else        nxt = sda_s ? S_START : S_CLO;
        end else if (tmr_exp) begin
          nxt = S_IDLE; fin = 1'b1; fin_code = RES_SCL_STUCK;
        end
      end
      S_START: if (tmr_exp) nxt = S_SHOLD;
      S_SHOLD: if (tmr_exp) nxt = S_CLO;
      S_CLO:   if (tmr_exp) nxt = S_CREL;
      S_CREL: begin
        if (scl_s) nxt = S_CHI;
        else if (tmr_exp) begin
          nxt = S_IDLE; fin = 1'b1; fin_code = RES_SCL_STUCK;
        end
      end
      S_CHI: begin
        if (tmr_exp) begin
          pinc = 1'b1;
          if (!mode_q) nxt = last_pulse ? S_PPREP : S_GAP;
          else if (sda_s) nxt = S_PPREP;
          else if (last_pulse) begin
            nxt = S_IDLE; fin = 1'b1; fin_code = RES_SDA_STUCK;
          end else nxt = S_CLO;
        end
      end
      S_GAP:   if (tmr_exp) nxt = sda_s ? S_START : S_CLO;
      S_PPREP: if (tmr_exp) nxt = S_PLO;
      S_PLO:   if (tmr_exp) nxt = S_PREL;
      S_PREL: begin
        if (scl_s) nxt = S_PHI;
        else if (tmr_exp) begin
          nxt = S_IDLE; fin = 1'b1; fin_code = RES_SCL_STUCK;
        end
      end
      S_PHI:   if (tmr_exp) nxt = S_PROP;
      S_PROP: begin
        if (tmr_exp) begin
          nxt = S_IDLE; fin = 1'b1;
          fin_code = sda_s ? RES_OK : RES_SDA_STUCK;
        end
      end
      default: nxt = S_IDLE;
    endcase
  end

  // Line drive decode, registered so the pins never glitch
  function automatic logic scl_drv(input rec_state_e s);
    return (s == S_SHOLD) || (s == S_CLO) || (s == S_PPREP) || (s == S_PLO);
  endfunction

  function automatic logic sda_drv(input rec_state_e s);
    return (s == S_START) || (s == S_SHOLD) || (s == S_PLO) ||
           (s == S_PREL) || (s == S_PHI);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      mode_q    <= 1'b0;
      pcnt      <= '0;
      scl_low_q <= 1'b0;
      sda_low_q <= 1'b0;
      done_q    <= 1'b0;
      res_q     <= RES_OK;
    end else begin
      st        <= nxt;
      scl_low_q <= scl_drv(nxt);
      sda_low_q <= sda_drv(nxt);
      done_q    <= fin;
      if (fin) res_q <= fin_code;
      if (st == S_IDLE && start_i) begin
        mode_q <= mode_i;
        pcnt   <= '0;
      end else if (pinc) begin
        pcnt <= pcnt + 1'b1;
      end
    end
  end

  assign scl_low_o = scl_low_q;
  assign sda_low_o = sda_low_q;
  assign busy_o    = (st != S_IDLE);
  assign done_o    = done_q;
  assign result_o  = res_q;

  // R2
  released_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!scl_low_o && !sda_low_o));
  // R9
  start_needs_sda_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sda_low_o) && !scl_low_o) |-> $past(sda_s));
  // R7
  pulse_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pcnt <= PW'(NUM_PULSES));
  // R11
  mode_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> $stable(mode_q));
  // R12
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R12
  done_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);
  // R12
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(result_o));
endmodule

// File: tb/tb_i2c_bus_recover.sv
module tb_i2c_bus_recover;
  localparam int NP = 9, SETTLE = 6, GAP = 3, LO = 4, HI = 4, PROP = 5, STRETCH = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, mode_i = 1'b0;
  logic tb_scl_hold = 1'b0, tb_sda_hold = 1'b0;
  logic scl_line, sda_line;
  logic scl_low_o, sda_low_o, busy_o, done_o;
  logic [1:0] result_o;

  assign scl_line = ~(scl_low_o | tb_scl_hold);
  assign sda_line = ~(sda_low_o | tb_sda_hold);

  i2c_bus_recover #(
    .NUM_PULSES(NP), .SETTLE_CYC(SETTLE), .GAP_CYC(GAP), .LO_CYC(LO),
    .HI_CYC(HI), .PROP_CYC(PROP), .STRETCH_CYC(STRETCH)
  ) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
    .scl_i(scl_line), .sda_i(sda_line),
    .scl_low_o(scl_low_o), .sda_low_o(sda_low_o),
    .busy_o(busy_o), .done_o(done_o), .result_o(result_o)
  );

  always #10 clk = ~clk;  // 20 time units per cycle: 50 MHz

  int n_chk = 0, n_fail = 0;
  int m_rises, m_starts, m_stops, m_busy, m_done, m_res, m_s2d, m_rel_ok;

  // columns: mode, sda release after rise k (0 none, 99 never), scl hold (255 for ever),
  //          expected result, SCL rises, STARTs, STOPs
  localparam int NROW = 9;
  localparam int TBL [NROW][7] = '{
    '{0,  0,   0, 0, 10, 9, 1},  // R1 free bus, interleaved
    '{1,  0,   0, 0,  1, 0, 1},  // R5 STOP only
    '{1,  3,   0, 0,  5, 0, 1},  // R6 release in pulse 4
    '{0,  3,   0, 0, 10, 5, 1},  // R9 START withheld while SDA low
    '{1, 99,   0, 1,  9, 0, 0},  // R7 never released
    '{0, 99,   0, 1, 10, 0, 0},  // R9 interleaved, never released
    '{1,  8,   0, 0, 10, 0, 1},  // R6 release in the ninth pulse
    '{1,  0,  10, 0,  2, 0, 1},  // R10 short stretch
    '{1,  0, 255, 2,  0, 0, 0}   // R8 SCL stuck from the start
  };

  function automatic string row_tag(input int r);
    case (r)
      0: return "R1";
      1: return "R5";
      2: return "R6";
      3: return "R9";
      4: return "R7";
      5: return "R9";
      6: return "R6";
      7: return "R10";
      default: return "R8";
    endcase
  endfunction

  task automatic chk_eq(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_case(input int mode, input int k, input int hold,
                          input int grab, input bit mid_start);
    int stop_cyc, done_cyc, hold_left, falls;
    logic ps, pd, cs, cd;
    stop_cyc = -1; done_cyc = -1; hold_left = hold; falls = 0;
    m_rises = 0; m_starts = 0; m_stops = 0; m_busy = 0; m_done = 0;
    m_res = -1; m_s2d = -1; m_rel_ok = 1;
    tb_sda_hold = (k != 0);
    tb_scl_hold = (hold != 0);
    repeat (4) @(negedge clk);
    ps = scl_line; pd = sda_line;
    for (int cyc = 0; cyc < 4000; cyc++) begin
      if (cyc > 0) @(negedge clk);
      start_i = (cyc == 0) || (mid_start && cyc == 40);
      mode_i  = (cyc == 0) ? mode[0] : ~mode[0];
      cs = scl_line; cd = sda_line;
      if (!ps && cs) m_rises++;
      if (ps && cs && pd && !cd) m_starts++;
      if (ps && cs && !pd && cd) begin m_stops++; stop_cyc = cyc; end
      if (busy_o) m_busy++;
      if (done_o) begin
        m_done++;
        if (done_cyc < 0) begin
          done_cyc = cyc;
          m_res = int'(result_o);
          if (scl_low_o || sda_low_o) m_rel_ok = 0;
        end
      end
      // target model
      if (k != 0 && k != 99 && tb_sda_hold && m_rises >= k && ps && !cs) tb_sda_hold = 1'b0;
      if (hold != 0 && hold != 255) begin
        if (hold_left > 0) hold_left--;
        if (hold_left == 0) tb_scl_hold = 1'b0;
      end
      if (grab != 0 && ps && !cs) begin
        falls++;
        if (falls == grab) tb_scl_hold = 1'b1;
      end
      ps = cs; pd = cd;
      if (done_cyc >= 0 && cyc >= done_cyc + 6) break;
    end
    start_i = 1'b0;
    if (stop_cyc >= 0 && done_cyc >= 0) m_s2d = done_cyc - stop_cyc;
    if (done_cyc < 0) chk_eq("R12 watchdog: run never completed", 0, 1);
  endtask

  initial begin
    #(64'd200000 * 20);
    $display("FAIL watchdog expired R12 actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk + 1, n_fail + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R13 reset state
    chk_eq("R13 scl_low_o in reset", int'(scl_low_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk_eq("R13 sda_low_o after reset", int'(sda_low_o), 0);
    chk_eq("R13 busy_o after reset", int'(busy_o), 0);
    chk_eq("R13 done_o after reset", int'(done_o), 0);
    chk_eq("R13 result_o after reset", int'(result_o), 0);

    for (int r = 0; r < NROW; r++) begin
      run_case(TBL[r][0], TBL[r][1], TBL[r][2], 0, 1'b0);
      chk_eq({row_tag(r), " result"}, m_res, TBL[r][3]);
      chk_eq({row_tag(r), " SCL rises"}, m_rises, TBL[r][4]);
      chk_eq({row_tag(r), " STARTs"}, m_starts, TBL[r][5]);
      chk_eq({row_tag(r), " STOPs"}, m_stops, TBL[r][6]);
      chk_eq("R2 lines released at done", m_rel_ok, 1);
      tb_scl_hold = 1'b0; tb_sda_hold = 1'b0;
    end

    // R3 settle, gaps, ninth gap skipped; R4 propagation wait
    run_case(0, 0, 0, 0, 1'b0);
    chk_eq("R3 busy cycles interleaved", m_busy, 234);
    chk_eq("R4 STOP to done cycles", m_s2d, PROP);
    chk_eq("R2 ends with STOP", m_stops, 1);
    run_case(1, 0, 0, 0, 1'b0);
    chk_eq("R3 busy cycles STOP only", m_busy, 21);
    chk_eq("R4 STOP to done cycles conditional", m_s2d, PROP);

    // R11 start request during a run
    run_case(0, 0, 0, 0, 1'b1);
    chk_eq("R11 rises with extra request", m_rises, 10);
    chk_eq("R11 STARTs with extra request", m_starts, 9);
    chk_eq("R11 done strobes", m_done, 1);
    chk_eq("R11 result", m_res, 0);

    // R8 SCL grabbed mid-sequence
    run_case(0, 0, 0, 3, 1'b0);
    chk_eq("R8 result mid-run clock stuck", m_res, 2);
    chk_eq("R8 lines released", m_rel_ok, 1);
    tb_scl_hold = 1'b0;

    // R12 done width and result hold
    run_case(1, 99, 0, 0, 1'b0);
    chk_eq("R12 done high cycles", m_done, 1);
    repeat (30) @(negedge clk);
    chk_eq("R12 result held", int'(result_o), 1);
    chk_eq("R12 done low afterwards", int'(done_o), 0);
    chk_eq("R12 busy low afterwards", int'(busy_o), 0);
    tb_sda_hold = 1'b0;

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule